// File: doc/BRIEF.md
# Raster sync counter chain

This block derives line and frame timing from one pixel-rate clock by chaining two binary counters. A horizontal counter steps on every clock. When a few of its bits are all set, a flag is captured, and on the following clock that flag both clears the counter and marks the end of the line. A vertical counter is built the same way. It advances only in clocks where the line-end pulse is high, so it counts lines and marks the end of each frame.

Both counts leave the block unchanged, so neighbouring logic can tap any bit as a square wave. Vertical bit 5, for example, gives a tone at one sixty-fourth of the line rate. Ending each count with a sparse AND of its bits, followed by one register, gives periods of 455 clocks per line and 262 lines per frame rather than powers of two. The block has no data stream and no handshake: the clock and a synchronous reset go in, and plain counts and pulses come out.

Top module: `raster_sync_chain`

## Requirements
- R1: While `rst` is sampled high on a rising clock edge, that edge sets `hcount` and `vcount` to 0 and drives `hreset` and `vreset` low.
- R2: `hcount` increases by exactly one on every clock, counts 0 through 454, and never shows a value above 454.
- R3: `hreset` is high for exactly one clock per line, in the clock where `hcount` reads 0 after a wrap. Successive pulses, and the first pulse after reset, are 455 clocks apart.
- R4: The line end is taken from the AND of `hcount` bits 1, 2, 6, 7 and 8 (weights 2, 4, 64, 128, 256, first matching at 454). That result is registered, so `hreset` rises on the edge that follows the clock in which `hcount` is 454.
- R5: `vcount` changes only on the edge that ends an `hreset` clock, at which edge it increases by one. It holds in every other clock and stays within 0 to 261.
- R6: The frame end is taken from the AND of `vcount` bits 0, 2 and 8 (first matching at 261). `vreset` rises on the same edge at which `vcount` returns from 261 to 0, which is the edge after the 262nd `hreset` following reset, when `hcount` reads 1. It stays high for exactly 455 clocks.
- R7: Because the frame wraps at 262 lines, `vcount` bit 5 toggles every 32 lines (32 × 455 clocks), except for the low stretch that spans the frame wrap, which lasts 38 lines (38 × 455 clocks).
- R8: A reset in the middle of a frame returns both counters to 0, and the first line after it is again a full 455 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hcount | output | 9 | Horizontal position within the line |
| vcount | output | 9 | Line number within the frame |
| hreset | output | 1 | One-clock line-end pulse |
| vreset | output | 1 | One-line-long frame-end pulse |

## Verification
The main stimulus is a free run from reset through one whole frame wrap and about 64 lines into the next frame. This run separates a correct sparse decode and register delay, which give a 455-clock line and a 262-line frame, from an off-by-one or a power-of-two wrap. It also shows whether the stretched 38-line low run of vertical bit 5 appears at the wrap. A second pattern asserts reset partway through the second frame. It shows whether both counters restart together and whether the first line after reset is a full period rather than a remnant of the old line.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int unsigned H_BITS_DEF = 9;
  localparam int unsigned V_BITS_DEF = 9;
  // Horizontal end-of-line taps: weights 2,4,64,128,256 -> first hit at 454
  localparam logic [H_BITS_DEF-1:0] H_TAPS_DEF = 9'b1_1100_0110;
  // Vertical end-of-frame taps: weights 1,4,256 -> first hit at 261
  localparam logic [V_BITS_DEF-1:0] V_TAPS_DEF = 9'b1_0000_0101;
endpackage

// File: rtl/tap_and.sv
module tap_and #(
  parameter int unsigned W = 9,
  parameter logic [W-1:0] TAPS = '1
) (
  input  logic [W-1:0] value,
  output logic         hit
);
  logic [W-1:0] term;

  // Untapped positions are forced true so only tapped bits matter
  for (genvar i = 0; i < W; i++) begin : g_term
    assign term[i] = value[i] | ~TAPS[i];
  end

  assign hit = &term;
endmodule

// File: rtl/sync_counter.sv
module sync_counter #(
  parameter int unsigned W = 9,
  parameter logic [W-1:0] TAPS = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] count,
  output logic         term
);
  logic hit;

  tap_and #(.W(W), .TAPS(TAPS)) u_dec (
    .value (count),
    .hit   (hit)
  );

  // Captured decode clears the count on the same edge it is raised
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      term  <= 1'b0;
    end else if (step) begin
      term  <= hit;
      count <= hit ? '0 : count + 1'b1;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(count)); // R5

  AST_TERM_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    term |-> (count == '0)); // R3

  AST_NEVER_PAST_TAP: assert property (@(posedge clk) disable iff (rst)
    count <= TAPS); // R2

  AST_TERM_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && term) |=> !term); // R3
endmodule

// File: rtl/raster_sync_chain.sv
module raster_sync_chain #(
  parameter int unsigned H_BITS = raster_pkg::H_BITS_DEF,
  parameter int unsigned V_BITS = raster_pkg::V_BITS_DEF,
  parameter logic [H_BITS-1:0] H_TAPS = raster_pkg::H_TAPS_DEF,
  parameter logic [V_BITS-1:0] V_TAPS = raster_pkg::V_TAPS_DEF
) (
  input  logic              clk,
  input  logic              rst,
  output logic [H_BITS-1:0] hcount,
  output logic [V_BITS-1:0] vcount,
  output logic              hreset,
  output logic              vreset
);
  sync_counter #(.W(H_BITS), .TAPS(H_TAPS)) u_horiz (
    .clk   (clk),
    .rst   (rst),
    .step  (1'b1),
    .count (hcount),
    .term  (hreset)
  );

  // Line counter advances only in the line-end clock
  sync_counter #(.W(V_BITS), .TAPS(V_TAPS)) u_vert (
    .clk   (clk),
    .rst   (rst),
    .step  (hreset),
    .count (vcount),
    .term  (vreset)
  );

  AST_HRESET_AFTER_TAP: assert property (@(posedge clk) disable iff (rst)
    hreset |-> (hcount == '0) && ($past(hcount) == H_TAPS)); // R4

  AST_HRESET_SINGLE: assert property (@(posedge clk) disable iff (rst)
    hreset |=> !hreset); // R3

  AST_VMOVE_ON_LINE_END: assert property (@(posedge clk) disable iff (rst)
    !$stable(vcount) |-> $past(hreset)); // R5

  AST_VRESET_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(vreset) |-> $past(hreset) && (vcount == '0) && ($past(vcount) == V_TAPS)); // R6
endmodule

// File: tb/raster_sync_chain_test.sv
module raster_sync_chain_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rst_q = 1'b1;
  logic [8:0] hcount, vcount;
  logic       hreset, vreset;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int line_q[$];
  int run_q[$];

  int prev_h, prev_v;
  logic prev_hr, prev_vr, prev_b5;
  int clk_in_line, hr_pulses, vr_high, run_len;
  bit frame_checked = 0;
  bit run_first = 1;
  bit run_on = 1;
  bit after_mid = 0;
  bit first_line = 1;

  raster_sync_chain uut (
    .clk    (clk),
    .rst    (rst),
    .hcount (hcount),
    .vcount (vcount),
    .hreset (hreset),
    .vreset (vreset)
  );

  always #5 clk = ~clk;

  always @(posedge clk) rst_q <= rst;

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load_expectations();
    for (int i = 0; i < 340; i++) line_q.push_back(455);
    for (int i = 0; i < 7; i++) run_q.push_back(32 * 455);
    run_q.push_back(38 * 455);
    run_q.push_back(32 * 455);
  endtask

  // Monitor: compares outputs away from the active edge
  always @(negedge clk) begin
    if (rst_q) begin
      check(hcount == 0, after_mid ? "R8 reset hcount" : "R1 reset hcount", int'(hcount), 0);
      check(vcount == 0, after_mid ? "R8 reset vcount" : "R1 reset vcount", int'(vcount), 0);
      check(!hreset && !vreset, "R1 reset pulses low", int'({hreset, vreset}), 0);
      prev_h = 0; prev_v = 0; prev_hr = 0; prev_vr = 0; prev_b5 = 0;
      clk_in_line = 0; hr_pulses = 0; vr_high = 0; run_len = 0;
      run_first = 1; first_line = 1;
    end else begin
      int exp_h, exp_v;
      bit exp_vr;
      exp_h = (prev_h == 454) ? 0 : prev_h + 1;
      check(int'(hcount) == exp_h, "R2 hcount step", int'(hcount), exp_h);
      check(int'(hcount) <= 454, "R2 hcount range", int'(hcount), 454);
      check(hreset == (prev_h == 454), "R4 registered line decode", int'(hreset), int'(prev_h == 454));
      exp_v = prev_hr ? ((prev_v == 261) ? 0 : prev_v + 1) : prev_v;
      check(int'(vcount) == exp_v, "R5 vcount step", int'(vcount), exp_v);
      check(int'(vcount) <= 261, "R5 vcount range", int'(vcount), 261);
      exp_vr = prev_hr ? (prev_v == 261) : prev_vr;
      check(vreset == exp_vr, "R6 vreset level", int'(vreset), int'(exp_vr));

      clk_in_line++;
      if (hreset) begin
        hr_pulses++;
        if (line_q.size() > 0) begin
          int e;
          e = line_q.pop_front();
          check(clk_in_line == e, (after_mid && first_line) ? "R8 first line period" : "R3 line period",
                clk_in_line, e);
        end
        first_line = 0;
        clk_in_line = 0;
      end

      if (vreset && !prev_vr) begin
        if (!frame_checked) check(hr_pulses == 262, "R6 lines per frame", hr_pulses, 262);
        frame_checked = 1;
        check(int'(hcount) == 1, "R6 vreset rise position", int'(hcount), 1);
      end
      if (vreset) vr_high++;
      else if (prev_vr) begin
        check(vr_high == 455, "R6 vreset width", vr_high, 455);
        vr_high = 0;
      end

      if (run_on) begin
        if (vcount[5] != prev_b5) begin
          if (!run_first && run_q.size() > 0) begin
            int e;
            e = run_q.pop_front();
            check(run_len == e, "R7 bit5 run length", run_len, e);
          end
          run_first = 0;
          run_len = 1;
        end else begin
          run_len++;
        end
      end

      prev_h = int'(hcount); prev_v = int'(vcount);
      prev_hr = hreset; prev_vr = vreset; prev_b5 = vcount[5];
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Driver
  initial begin
    load_expectations();
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    wait (run_q.size() == 0);
    run_on = 0;
    repeat (200) @(posedge clk);
    check(frame_checked, "R6 frame end observed", int'(frame_checked), 1);
    check(vcount != 0, "R8 reset taken mid-frame", int'(vcount), 1);
    #2 rst = 1'b1;
    after_mid = 1;
    repeat (2) @(posedge clk);
    #2 rst = 1'b0;
    repeat (1000) @(posedge clk);
    check(hr_pulses == 2, "R8 line pulses after reset", hr_pulses, 2);
    done = 1;
    finish_run();
  end

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end
endmodule